// File: doc/BRIEF.md
# Clock Source Switch Controller

This block holds the control and status word that selects the system clock source and runs the sequence that moves the system from one source to another. Software names a target source in a 3-bit field and sets a start bit. The sequencer then judges the request against the freeze rule, the reserved code and the ban on hopping straight between the two PLL sources. It waits until the target source reports ready, and also for PLL lock when the target uses the PLL. It then commits the new source to the read-only current-source field and to the clock mux select, and drops the start bit.

Writes to the control word are guarded by a two-write key sequence on a separate key register. Only the single control write that follows the keys is taken. The word also holds a pin-mapping lock bit that drives an output, a mirror of the PLL lock status, and a sticky clock-fail flag. The oscillators and the glitch-free mux sit outside the block and appear here only as ready inputs and a select output.

Top module: `clksw_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, the current-source field (bits 14:12), the target field (bits 10:8) and `mux_sel` equal `cfg_src`, and every other bit of `ctl_rdata` is 0.
- R2: `ctl_rdata` shows the current source at 14:12, the target at 10:8, the freeze bit at 7, the pin-map lock at 6, the PLL-lock mirror at 5, the fail flag at 3 and the start bit at 0. Bits 15, 11, 4, 2 and 1 always read 0.
- R3: A write with `bus_key_sel`=0 changes the control word only when the two bus writes just before it were 16'hC3A5 and then 16'h3C5A, both with `bus_key_sel`=1. Any other write in between cancels the sequence.
- R4: One key sequence admits exactly one control write. A second control write without new keys has no effect.
- R5: An allowed switch waits while `src_rdy[target]` is low, or while `pll_lock` is low if the target is 001 or 011. On the first cycle both hold, the current field and `mux_sel` take the target and the start bit clears. With everything ready this happens two clocks after the control write.
- R6: A request for code 100 clears the start bit one clock after the write and leaves the current source unchanged.
- R7: A request from 011 to 001, or from 001 to 011, is refused the same way as in R6. All other pairs among the seven legal codes are carried out.
- R8: When `cfg_swen`=1 and `cfg_fscm`=0, a set freeze bit refuses every switch. With `cfg_fscm`=1 the freeze bit has no effect. With `cfg_swen`=0 every switch is refused.
- R9: `io_lock` equals the pin-map lock bit (write bit 6).
- R10: Bit 5 shows `pll_lock` delayed by one clock.
- R11: The fail flag (bit 3) is set by `clk_fail` and stays set. An accepted write with bit 3 = 0 clears it. Writing 1 to it does not set it.
- R12: Write data in bits 14:12 never changes the current-source field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_src | input | 3 | Configured source loaded at reset |
| cfg_swen | input | 1 | Configuration: switching enabled |
| cfg_fscm | input | 1 | Configuration: fail-safe monitor enabled |
| bus_we | input | 1 | Bus write strobe |
| bus_key_sel | input | 1 | 1 = key register, 0 = control word |
| bus_wdata | input | 16 | Bus write data |
| src_rdy | input | 8 | Ready flag per source code |
| pll_lock | input | 1 | PLL lock status |
| clk_fail | input | 1 | Clock failure event |
| ctl_rdata | output | 16 | Control/status word |
| mux_sel | output | 3 | Clock mux select |
| io_lock | output | 1 | Pin-mapping write lock |

## Verification
The bench sweeps all 64 pairs of current and target code, starting each from reset. This catches a design that lets a PLL-to-PLL hop through, accepts the reserved code, or refuses a legal pair. Refusals are sampled exactly one clock after the write, so a design that idles in the wait state instead of aborting at once is caught. The bench withholds ready or PLL lock and confirms the switch stalls, which catches a sequencer that commits early. Broken and repeated key sequences catch a write gate that stays open or accepts stale keys. Freeze is tried under all three configuration cases, and writing 1 to the fail flag exposes a flag that can be set by software.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SEL_W = 3;
  localparam int N_SRC = 1 << SEL_W;
  typedef logic [SEL_W-1:0] src_t;
  localparam src_t SRC_FRC     = 3'd0;
  localparam src_t SRC_FRC_PLL = 3'd1;
  localparam src_t SRC_PRI     = 3'd2;
  localparam src_t SRC_PRI_PLL = 3'd3;
  localparam src_t SRC_RSVD    = 3'd4;

  function automatic logic uses_pll(src_t s);
    return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
  endfunction

  function automatic logic pll_hop(src_t cur, src_t tgt);
    return (cur == SRC_PRI_PLL && tgt == SRC_FRC_PLL) ||
           (cur == SRC_FRC_PLL && tgt == SRC_PRI_PLL);
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock #(
  parameter int          DW    = 16,
  parameter logic [15:0] KEY_A = 16'hC3A5,
  parameter logic [15:0] KEY_B = 16'h3C5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          key_sel,
  input  logic [DW-1:0] wdata,
  output logic          ctl_wr_ok
);
  typedef enum logic [1:0] {K_IDLE, K_HALF, K_OPEN} kst_t;
  kst_t st;

  assign ctl_wr_ok = we && !key_sel && (st == K_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_IDLE;
    end else if (we) begin
      case (st)
        K_IDLE:  st <= (key_sel && wdata == KEY_A) ? K_HALF : K_IDLE;
        K_HALF:  st <= (key_sel && wdata == KEY_B) ? K_OPEN : K_IDLE;
        default: st <= K_IDLE;
      endcase
    end
  end

  // R4: an accepted write closes the gate
  a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_ok |=> !ctl_wr_ok);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  src_t          cur,
  input  src_t          req,
  input  logic          freeze,
  input  logic          sw_en,
  input  logic [NS-1:0] src_rdy,
  input  logic          pll_lock,
  output logic          commit,
  output logic          abort,
  output src_t          tgt
);
  typedef enum logic {S_IDLE, S_WAIT} sst_t;
  sst_t st;
  logic [NS-1:0] eff_rdy;
  logic          refuse;

  for (genvar i = 0; i < NS; i++) begin : g_rdy
    if (uses_pll(src_t'(i))) begin : g_pll
      assign eff_rdy[i] = src_rdy[i] & pll_lock;
    end else begin : g_plain
      assign eff_rdy[i] = src_rdy[i];
    end
  end

  assign refuse = !sw_en || freeze || (req == SRC_RSVD) || pll_hop(cur, req);
  assign abort  = (st == S_IDLE) && start && refuse;
  assign commit = (st == S_WAIT) && eff_rdy[tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      tgt <= SRC_FRC;
    end else begin
      case (st)
        S_IDLE: if (start && !refuse) begin
          st  <= S_WAIT;
          tgt <= req;
        end
        default: if (eff_rdy[tgt]) st <= S_IDLE;
      endcase
    end
  end

  // R6: a reserved request never enters the wait state
  a_r6_reserved_refused: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && req == SRC_RSVD) |=> st == S_IDLE);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int          DW    = 16,
  parameter logic [15:0] KEY_A = 16'hC3A5,
  parameter logic [15:0] KEY_B = 16'h3C5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cfg_src,
  input  logic          cfg_swen,
  input  logic          cfg_fscm,
  input  logic          bus_we,
  input  logic          bus_key_sel,
  input  logic [DW-1:0] bus_wdata,
  input  logic [7:0]    src_rdy,
  input  logic          pll_lock,
  input  logic          clk_fail,
  output logic [DW-1:0] ctl_rdata,
  output logic [2:0]    mux_sel,
  output logic          io_lock
);
  localparam int B_COSC = 12;
  localparam int B_NOSC = 8;
  localparam int B_FRZ  = 7;
  localparam int B_IOL  = 6;
  localparam int B_LCK  = 5;
  localparam int B_CF   = 3;
  localparam int B_GO   = 0;

  src_t cosc, nosc, tgt;
  logic frz_bit, iol_bit, lck_bit, cf_bit, go_bit;
  logic ctl_wr_ok, commit, abort, seen_q;

  clksw_unlock #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) unlock_i (
    .clk(clk), .rst(rst), .we(bus_we), .key_sel(bus_key_sel),
    .wdata(bus_wdata), .ctl_wr_ok(ctl_wr_ok));

  clksw_seq #(.NS(N_SRC)) seq_i (
    .clk(clk), .rst(rst), .start(go_bit), .cur(cosc), .req(nosc),
    .freeze(frz_bit && cfg_swen && !cfg_fscm), .sw_en(cfg_swen),
    .src_rdy(src_rdy), .pll_lock(pll_lock),
    .commit(commit), .abort(abort), .tgt(tgt));

  always_ff @(posedge clk) begin
    if (rst) begin
      cosc    <= cfg_src;
      nosc    <= cfg_src;
      frz_bit <= 1'b0;
      iol_bit <= 1'b0;
      lck_bit <= 1'b0;
      cf_bit  <= 1'b0;
      go_bit  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      seen_q  <= 1'b1;
      lck_bit <= pll_lock;
      cf_bit  <= clk_fail | (cf_bit & ~(ctl_wr_ok & ~bus_wdata[B_CF]));
      if (ctl_wr_ok) begin
        nosc    <= bus_wdata[B_NOSC +: SEL_W];
        frz_bit <= bus_wdata[B_FRZ];
        iol_bit <= bus_wdata[B_IOL];
      end
      if (commit) cosc <= tgt;
      if (commit || abort)                  go_bit <= 1'b0;
      else if (ctl_wr_ok && bus_wdata[B_GO]) go_bit <= 1'b1;
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[B_COSC +: SEL_W] = cosc;
    ctl_rdata[B_NOSC +: SEL_W] = nosc;
    ctl_rdata[B_FRZ] = frz_bit;
    ctl_rdata[B_IOL] = iol_bit;
    ctl_rdata[B_LCK] = lck_bit;
    ctl_rdata[B_CF]  = cf_bit;
    ctl_rdata[B_GO]  = go_bit;
  end

  assign mux_sel = cosc;
  assign io_lock = iol_bit;

  // R3: the target field moves only on a write let through by the key gate
  a_r3_nosc_guarded: assert property (@(posedge clk) disable iff (rst || !seen_q)
    (nosc != $past(nosc)) |-> $past(ctl_wr_ok));
  // R7: no direct hop between the two PLL sources
  a_r7_no_pri_to_frc_pll: assert property (@(posedge clk) disable iff (rst || !seen_q)
    ($past(cosc) == SRC_PRI_PLL) |-> cosc != SRC_FRC_PLL);
  a_r7_no_frc_to_pri_pll: assert property (@(posedge clk) disable iff (rst || !seen_q)
    ($past(cosc) == SRC_FRC_PLL) |-> cosc != SRC_PRI_PLL);
  // R5: a new source is committed only after it reported ready
  a_r5_ready_before_switch: assert property (@(posedge clk) disable iff (rst || !seen_q)
    (cosc != $past(cosc)) |-> $past(src_rdy[cosc]));
  // R11: the fail flag drops only through an accepted write
  a_r11_cf_sticky: assert property (@(posedge clk) disable iff (rst || !seen_q)
    ($past(cf_bit) && !$past(ctl_wr_ok)) |-> cf_bit);
endmodule

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb_top;
  localparam logic [15:0] KA = 16'hC3A5;
  localparam logic [15:0] KB = 16'h3C5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_src = 3'd0;
  logic        cfg_swen = 1'b1, cfg_fscm = 1'b0;
  logic        bus_we = 1'b0, bus_key_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  src_rdy = 8'hFF;
  logic        pll_lock = 1'b1, clk_fail = 1'b0;
  logic [15:0] ctl_rdata;
  logic [2:0]  mux_sel;
  logic        io_lock;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  clksw_ctrl #(.KEY_A(KA), .KEY_B(KB)) dut_i (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_swen(cfg_swen),
    .cfg_fscm(cfg_fscm), .bus_we(bus_we), .bus_key_sel(bus_key_sel),
    .bus_wdata(bus_wdata), .src_rdy(src_rdy), .pll_lock(pll_lock),
    .clk_fail(clk_fail), .ctl_rdata(ctl_rdata), .mux_sel(mux_sel),
    .io_lock(io_lock));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] src);
    @(negedge clk); rst = 1'b1; cfg_src = src;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(logic key, logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_key_sel = key; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic unlock();
    wr(1'b1, KA); wr(1'b1, KB);
  endtask

  function automatic logic [15:0] req_word(logic [2:0] t, logic go);
    return {5'b0, t, 7'b0, go};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1, R2 reset state
    do_reset(3'd6);
    chk("R1 rdata", {16'b0, ctl_rdata}, 32'h6600);
    chk("R1 mux_sel", mux_sel, 6);
    chk("R2 unused bits", ctl_rdata & 16'h8816, 0);

    // R7, R5, R6: sweep of all current/target pairs
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 8; t++) begin
        logic refuse;
        refuse = (t == 4) || (c == 3 && t == 1) || (c == 1 && t == 3);
        do_reset(c[2:0]);
        unlock();
        wr(1'b0, req_word(t[2:0], 1'b1));
        @(negedge clk);
        if (refuse) begin
          chk("R7/R6 refused start bit", ctl_rdata[0], 0);
          chk("R7/R6 refused current", ctl_rdata[14:12], c);
        end else begin
          chk("R5 still pending", ctl_rdata[0], 1);
          @(negedge clk);
          chk("R7 allowed current", ctl_rdata[14:12], t);
          chk("R5 mux_sel", mux_sel, t);
          chk("R5 start cleared", ctl_rdata[0], 0);
        end
      end
    end

    // R5 wait on ready, then on PLL lock
    do_reset(3'd0);
    src_rdy = 8'hFB;
    unlock(); wr(1'b0, req_word(3'd2, 1'b1));
    repeat (5) @(negedge clk);
    chk("R5 stalled on ready", {ctl_rdata[14:12], ctl_rdata[0]}, 4'b0001);
    src_rdy = 8'hFF;
    @(negedge clk);
    chk("R5 done after ready", mux_sel, 2);
    pll_lock = 1'b0;
    unlock(); wr(1'b0, req_word(3'd3, 1'b1));
    repeat (5) @(negedge clk);
    chk("R5 stalled on pll", mux_sel, 2);
    chk("R10 lock mirror low", ctl_rdata[5], 0);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R5 done after pll", mux_sel, 3);
    chk("R10 lock mirror high", ctl_rdata[5], 1);

    // R3 / R4 / R12 key gate
    do_reset(3'd0);
    wr(1'b0, req_word(3'd5, 1'b0));
    chk("R3 no keys", ctl_rdata[10:8], 0);
    wr(1'b1, KA); wr(1'b0, req_word(3'd5, 1'b0)); wr(1'b1, KB);
    wr(1'b0, req_word(3'd5, 1'b0));
    chk("R3 broken keys", ctl_rdata[10:8], 0);
    wr(1'b1, KB); wr(1'b1, KA);
    wr(1'b0, req_word(3'd5, 1'b0));
    chk("R3 swapped keys", ctl_rdata[10:8], 0);
    unlock(); wr(1'b0, 16'h7000 | req_word(3'd5, 1'b0));
    chk("R3 accepted", ctl_rdata[10:8], 5);
    chk("R12 current untouched", ctl_rdata[14:12], 0);
    wr(1'b0, req_word(3'd6, 1'b0));
    chk("R4 second write ignored", ctl_rdata[10:8], 5);

    // R9 pin-map lock
    unlock(); wr(1'b0, 16'h0040 | req_word(3'd5, 1'b0));
    chk("R9 io_lock set", io_lock, 1);
    chk("R9 bit6", ctl_rdata[6], 1);
    unlock(); wr(1'b0, req_word(3'd5, 1'b0));
    chk("R9 io_lock clear", io_lock, 0);

    // R8 freeze under each configuration
    do_reset(3'd0);
    unlock(); wr(1'b0, 16'h0080 | req_word(3'd2, 1'b1));
    @(negedge clk); @(negedge clk);
    chk("R8 frozen", {ctl_rdata[14:12], ctl_rdata[0]}, 4'b0000);
    cfg_fscm = 1'b1;
    unlock(); wr(1'b0, 16'h0080 | req_word(3'd2, 1'b1));
    @(negedge clk); @(negedge clk);
    chk("R8 freeze ignored with monitor", ctl_rdata[14:12], 2);
    cfg_fscm = 1'b0; cfg_swen = 1'b0;
    unlock(); wr(1'b0, req_word(3'd0, 1'b1));
    @(negedge clk); @(negedge clk);
    chk("R8 switching disabled", {ctl_rdata[14:12], ctl_rdata[0]}, 4'b0100);
    cfg_swen = 1'b1;

    // R11 fail flag
    do_reset(3'd0);
    unlock(); wr(1'b0, 16'h0008);
    chk("R11 write 1 does not set", ctl_rdata[3], 0);
    @(negedge clk); clk_fail = 1'b1; @(negedge clk); clk_fail = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 sticky", ctl_rdata[3], 1);
    unlock(); wr(1'b0, 16'h0008);
    chk("R11 write 1 keeps", ctl_rdata[3], 1);
    unlock(); wr(1'b0, 16'h0000);
    chk("R11 write 0 clears", ctl_rdata[3], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule